// File: doc/BRIEF.md
# Remap enable command and status controller

This block holds the global command word and the global status word of an address-remapping unit that sits in front of DMA traffic. Software writes a 32-bit command word over a simple register bus. Bit 31 of that word asks for remapping to be switched on or off. The block does not apply the request at once. It raises a stall so that no new translated transaction starts, and waits until every outstanding translated request has finished. It then flips the remap-enable signal that drives the translation datapath, at a cycle where no transaction is starting.

The datapath reports each translated transaction with a start pulse when it begins and an end pulse when it completes. The block keeps the outstanding count from these pulses. Software learns that a request has completed by reading bit 31 of the separate status word. The command bit cannot be read back.

Top module: `remap_gate_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `remapEn` is 0, `stall` is 0, and reads at any address return 0.
- R2: A read at the command offset 0x18 returns 0x00000000, including the enable bit. A read at any offset other than 0x18 and 0x1C also returns 0.
- R3: A read at the status offset 0x1C returns `remapEn` in bit 31 and 0 in bits 30..0.
- R4: A write to offset 0x1C, or to any offset other than 0x18, changes neither `remapEn` nor `stall` nor the status word.
- R5: Suppose a write to 0x18 has bit 31 different from the applied state. Then `stall` is 1 from the next cycle, and `remapEn` keeps its old value while the drain is pending. Bits 30..0 of the write have no effect.
- R6: A pending request is applied in a cycle with zero outstanding transactions, no `txnStart`, and no command write. At the following clock edge, `remapEn` takes the requested value and `stall` returns to 0 together.
- R7: A write to 0x18 whose bit 31 equals the applied state completes at once. It does not raise `stall`, does not change `remapEn`, and cancels any pending request.
- R8: A command write that arrives while a drain is pending is accepted. Only the latest requested value is applied when the drain finishes.
- R9: The outstanding count rises on `txnStart` and falls on `txnEnd`. When both pulse in the same cycle, the count is unchanged. A `txnEnd` with nothing outstanding is ignored.
- R10: `remapEn` never changes at an edge where `txnStart` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| txnStart | input | 1 | A translated transaction begins this cycle |
| txnEnd | input | 1 | A translated transaction completes this cycle |
| remapEn | output | 1 | Applied remap-enable to the translation datapath |
| stall | output | 1 | Hold new transactions; a mode switch is pending |

## Verification
The enable request is tried in several situations. With the datapath idle, it shows the minimum two-cycle completion. With several transactions outstanding and ending one by one, it shows that the switch waits for the count to reach zero. With start pulses arriving during the drain, it shows that the switch is deferred to a boundary. With simultaneous start and end pulses and with end pulses on an empty count, it tells a correct counter from one that wraps or double-counts. Rewrites during a drain separate three behaviours: keeping the first value, taking the latest value, and cancelling the request. Writes to the status offset, writes to unmapped offsets, and writes with only the low bits set show that nothing but bit 31 at 0x18 has any effect.

// File: rtl/remap_gate_pkg.sv
package remap_gate_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int EN_BIT   = 31;
  localparam logic [ADDR_W-1:0] CMD_OFS = 8'h18;
  localparam logic [ADDR_W-1:0] STS_OFS = 8'h1C;

  typedef struct packed {
    logic loadReq;   // capture a new requested enable value
    logic applyReq;  // copy the requested value to the applied state
  } gateStrobes_t;
endpackage

// File: rtl/remap_gate_ctl.sv
module remap_gate_ctl
  import remap_gate_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdWrite,
  input  logic          wrBit,
  input  logic          appliedNow,
  input  logic          idleNow,
  input  logic          txnStart,
  output gateStrobes_t  strobes,
  output logic          pending
);
  logic drainDone;

  // a switch needs an empty pipe, a boundary and no racing command write
  assign drainDone        = pending && idleNow && !txnStart && !cmdWrite;
  assign strobes.loadReq  = cmdWrite;
  assign strobes.applyReq = drainDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (cmdWrite) begin
      pending <= (wrBit != appliedNow);
    end else if (drainDone) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/remap_gate_dp.sv
module remap_gate_dp
  import remap_gate_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobes_t      strobes,
  input  logic              wrBit,
  input  logic              txnStart,
  input  logic              txnEnd,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              appliedNow,
  output logic              idleNow
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             reqVal;
  logic             applied;
  logic [CNT_W-1:0] inFlight;
  logic             cntInc;
  logic             cntDec;

  assign cntInc = txnStart && !txnEnd;
  assign cntDec = txnEnd && !txnStart && (inFlight != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqVal   <= 1'b0;
      applied  <= 1'b0;
      inFlight <= '0;
    end else begin
      if (strobes.loadReq)  reqVal  <= wrBit;
      if (strobes.applyReq) applied <= reqVal;
      if (cntInc)      inFlight <= inFlight + CNT_ONE;
      else if (cntDec) inFlight <= inFlight - CNT_ONE;
    end
  end

  assign appliedNow = applied;
  assign idleNow    = (inFlight == '0);

  always_comb begin
    regRdData = '0;
    if (regAddr == STS_OFS) regRdData[EN_BIT] = applied;
  end
endmodule

// File: rtl/remap_gate_ctrl.sv
module remap_gate_ctrl
  import remap_gate_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txnStart,
  input  logic              txnEnd,
  output logic              remapEn,
  output logic              stall
);
  gateStrobes_t strobes;
  logic cmdWrite;
  logic wrBit;
  logic appliedNow;
  logic idleNow;
  logic pending;

  assign cmdWrite = regWrEn && (regAddr == CMD_OFS);
  assign wrBit    = regWrData[EN_BIT];

  remap_gate_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .wrBit(wrBit),
    .appliedNow(appliedNow), .idleNow(idleNow), .txnStart(txnStart),
    .strobes(strobes), .pending(pending)
  );

  remap_gate_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrBit(wrBit),
    .txnStart(txnStart), .txnEnd(txnEnd), .regAddr(regAddr),
    .regRdData(regRdData), .appliedNow(appliedNow), .idleNow(idleNow)
  );

  assign remapEn = appliedNow;
  assign stall   = pending;
endmodule

// File: rtl/remap_gate_chk.sv
module remap_gate_chk
  import remap_gate_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regRdData,
  input logic              txnStart,
  input logic              remapEn,
  input logic              stall
);
  // R6
  switch_needs_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(remapEn) |-> ($past(stall) && !stall));
  // R10
  switch_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(remapEn) |-> !$past(txnStart));
  // R5
  stall_from_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(regWrEn));
  // R7
  stall_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> (!$stable(remapEn) || $past(regWrEn)));
  // R2
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CMD_OFS) |-> (regRdData == '0));
  // R3
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == STS_OFS) |-> (regRdData[EN_BIT] == remapEn && regRdData[EN_BIT-1:0] == '0));
endmodule

bind remap_gate_ctrl remap_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regRdData(regRdData), .txnStart(txnStart), .remapEn(remapEn), .stall(stall)
);

// File: tb/remap_gate_ctrl_bench.sv
module remap_gate_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        txnStart = 1'b0;
  logic        txnEnd = 1'b0;
  logic        remapEn;
  logic        stall;

  int    nCmp = 0;
  int    nBad = 0;
  int    cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  bit mApplied = 0;
  bit mWanted  = 0;
  bit mPend    = 0;
  int mOut     = 0;

  always #10 clk = ~clk;

  remap_gate_ctrl u_remap_gate_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .txnStart(txnStart),
    .txnEnd(txnEnd), .remapEn(remapEn), .stall(stall)
  );

  always @(posedge clk) begin
    bit isCmd;
    cycles++;
    if (!rstN) begin
      mApplied = 0; mWanted = 0; mPend = 0; mOut = 0;
    end else begin
      isCmd = regWrEn && regAddr == 8'h18;
      if (isCmd) begin
        mWanted = regWrData[31];
        mPend   = (mWanted != mApplied);
      end else if (mPend && mOut == 0 && !txnStart) begin
        mApplied = mWanted;
        mPend    = 0;
      end
      if (txnStart && !txnEnd) mOut++;
      else if (txnEnd && !txnStart && mOut > 0) mOut--;
    end
  end

  task automatic check1(string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic cyc();
    logic [31:0] expRd;
    @(negedge clk);
    expRd = (regAddr == 8'h1C) ? {mApplied, 31'b0} : 32'h0;
    check1("remapEn", {31'b0, remapEn}, {31'b0, mApplied});
    check1("stall",   {31'b0, stall},   {31'b0, mPend});
    check1("regRdData", regRdData, expRd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    cyc();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(bit s, bit e);
    txnStart = s; txnEnd = e;
    cyc();
    txnStart = 1'b0; txnEnd = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finishRun();
    end
  end

  initial begin
    // R1: reset values
    curReq = "R1";
    idle(3);
    rstN = 1'b1;
    regAddr = 8'h1C; idle(1);
    check1("R1 status after reset", regRdData, 32'h0);

    // R2: command word reads zero, unmapped offset reads zero
    curReq = "R2";
    regAddr = 8'h18; idle(2);
    regAddr = 8'h04; idle(1);

    // R5 R6: enable with idle datapath
    curReq = "R5";
    wr(8'h18, 32'h8000_0000);
    check1("R5 stall after enable write", {31'b0, stall}, 32'h1);
    curReq = "R6";
    regAddr = 8'h1C; idle(1);
    check1("R6 enable applied", {31'b0, remapEn}, 32'h1);
    check1("R3 status mirrors", regRdData, 32'h8000_0000);
    curReq = "R3"; idle(1);

    // R7: same state write, no stall
    curReq = "R7";
    wr(8'h18, 32'h8000_0000);
    check1("R7 no stall", {31'b0, stall}, 32'h0);

    // R4: status writes and unmapped writes ignored
    curReq = "R4";
    wr(8'h1C, 32'h0);
    wr(8'h20, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF);
    check1("R4 remapEn kept", {31'b0, remapEn}, 32'h1);
    regAddr = 8'h1C; idle(1);

    // R9 R10: disable with outstanding transactions
    curReq = "R9";
    pulse(1, 0); pulse(1, 0); pulse(1, 1); pulse(1, 0);
    curReq = "R10";
    wr(8'h18, 32'h7FFF_FFFF);
    idle(2);
    check1("R10 held while busy", {31'b0, remapEn}, 32'h1);
    pulse(0, 1); pulse(0, 1); pulse(1, 0); pulse(0, 1);
    idle(1);
    pulse(0, 1);
    check1("R6 still pending at count one edge", {31'b0, stall}, 32'h1);
    pulse(1, 0);
    check1("R10 no switch on start", {31'b0, remapEn}, 32'h1);
    pulse(0, 1);
    curReq = "R9";
    pulse(0, 1); pulse(0, 1);
    idle(2);
    check1("R6 disable applied", {31'b0, remapEn}, 32'h0);

    // R8: rewrite during drain, latest wins
    curReq = "R8";
    pulse(1, 0);
    wr(8'h18, 32'h8000_0000);
    wr(8'h18, 32'h0);
    check1("R7 cancel clears stall", {31'b0, stall}, 32'h0);
    wr(8'h18, 32'h8000_0000);
    wr(8'h18, 32'h8000_0000);
    idle(2);
    check1("R8 held", {31'b0, remapEn}, 32'h0);
    pulse(0, 1);
    idle(2);
    check1("R8 latest applied", {31'b0, remapEn}, 32'h1);

    // R5: low bits alone have no effect
    curReq = "R5";
    wr(8'h18, 32'h8000_FFFF);
    wr(8'h18, 32'h0000_0001);
    wr(8'h18, 32'h8000_0000);
    idle(1);

    // R1: reset mid drain
    curReq = "R1";
    wr(8'h18, 32'h0);
    pulse(1, 0);
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(2);
    check1("R1 after second reset", {30'b0, remapEn, stall}, 32'h0);
    finishRun();
  end
endmodule